// File: doc/BRIEF.md
# CEC Multi-Buffer Receive Manager

This block sits between a bit-level CEC receiver and a host register interface. The receiver delivers each decoded frame one byte at a time, with a start marker, an end marker, an abort marker and a polling flag. The manager stores each frame in a receive buffer that holds up to 16 bytes, counting the header as the first byte. It records the frame length and gives each stored frame a small arrival-order stamp, so the host can drain frames in the order they arrived.

Each buffer has a latched ready bit, which is gated by a per-buffer interrupt mask. A level interrupt stays high while any masked ready bit is set. The host releases a buffer with a per-buffer clear strobe. An acknowledge-permission output tells the receiver whether there is room for another non-polling frame.

A small enable count limits how many buffers take part in allocation. With the minimum setting, every frame lands in buffer 0, and the receiver is refused until the host releases that buffer.

Top module: `cec_rx_buf_mgr`

## Requirements
- R1: A non-polling frame is stored in the lowest-numbered buffer that is both free and enabled, chosen when the frame starts.
- R2: Byte k of a stored frame, counting the header as byte 0, reads back at index k of its buffer. The stored length equals the bytes received, capped at 16. Bytes beyond the 16th are dropped.
- R3: Occupied buffers carry stamps 1, 2, 3 from oldest to newest, and a free buffer reads stamp 0. Clearing buffers lowers the stamp of each newer occupied buffer by the number of cleared buffers that were older than it.
- R4: At the cycle a frame is stored, the ready bit of that buffer takes the value of its mask bit. A set ready bit stays high until its clear strobe.
- R5: `irq` is high exactly when some ready bit is set together with its mask bit.
- R6: `ack_ok` is low exactly when every enabled buffer is occupied, and it returns high in the cycle after a clear frees one of them.
- R7: A frame ended with `fr_poll` high is not stored, changes no length or stamp, and sets no ready bit.
- R8: An enable count of 0 or 1 enables only buffer 0. A count of n enables buffers 0 to n-1, up to 3.
- R9: A frame ended by `fr_abort` leaves every ready bit, length and stamp unchanged, and its target buffer stays free.
- R10: A clear strobe frees an occupied buffer and resets its ready bit, length and stamp to 0. A clear of a free buffer has no visible effect.
- R11: A frame that starts while no enabled buffer is free is dropped, and no ready bit, length or stamp changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fr_start | input | 1 | First cycle of a frame |
| fr_byte_vld | input | 1 | `fr_byte` carries a frame byte this cycle |
| fr_byte | input | 8 | Frame byte, header first |
| fr_end | input | 1 | Frame completed |
| fr_abort | input | 1 | Frame abandoned (error or line reset) |
| fr_poll | input | 1 | Sampled with `fr_end`: the frame is a polling message |
| slot_clr | input | 3 | Per-buffer release strobe |
| slot_en_cnt | input | 2 | Number of buffers used for allocation |
| irq_mask | input | 3 | Per-buffer interrupt mask |
| rd_slot | input | 2 | Buffer selected for host reads |
| rd_idx | input | 4 | Byte index within the selected buffer |
| rd_data | output | 8 | Stored byte at `rd_slot`/`rd_idx` |
| rd_len | output | 5 | Length of the frame in `rd_slot` (0 when free) |
| rd_stamp | output | 2 | Arrival stamp of `rd_slot` |
| rdy_st | output | 3 | Latched per-buffer ready bits |
| irq | output | 1 | Host interrupt |
| ack_ok | output | 1 | Receiver may acknowledge a new non-polling frame |

## Verification
Broken occupancy shows up at the ports in the cycle after the end strobe. A frame then lands in the wrong buffer, or `ack_ok` stays high when every enabled buffer is full, and the ready bits and buffer reads expose the error at once. A wrong stamp update stays hidden until the host reads `rd_stamp` after a clear, so the bench reads stamps after every release pattern, including several buffers released in the same cycle. A bad abort or poll path leaves a ready bit or a non-zero length one cycle after the end strobe.

// File: rtl/cec_rxb_pkg.sv
// Shared constants and helpers for the CEC receive buffer manager.
// Assumes byte-wide frames and at most a handful of buffers.
package cec_rxb_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] cec_byte_t;

    // Index of the lowest set bit; returns 0 when none is set.
    function automatic int lowest_set(input logic [7:0] v, input int n);
        int r;
        r = 0;
        for (int i = n - 1; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction
endpackage

// File: rtl/cec_rxb_assembler.sv
// Frame assembler: picks the target buffer at frame start, steers incoming
// bytes into it, counts them (saturating at the buffer size) and issues a
// commit pulse at a good non-polling end. An abort discards the frame.
// Assumes fr_start may carry the header byte in the same cycle.
module cec_rxb_assembler
    import cec_rxb_pkg::*;
#(
    parameter int NUM_SLOTS  = 3,
    parameter int SLOT_BYTES = 16,
    localparam int SLW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int IW  = $clog2(SLOT_BYTES),
    localparam int LW  = $clog2(SLOT_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fr_start,
    input  logic                 fr_byte_vld,
    input  cec_byte_t            fr_byte,
    input  logic                 fr_end,
    input  logic                 fr_abort,
    input  logic                 fr_poll,
    input  logic [NUM_SLOTS-1:0] free_en,
    output logic                 wr_vld,
    output logic [SLW-1:0]       wr_slot,
    output logic [IW-1:0]        wr_idx,
    output cec_byte_t            wr_data,
    output logic                 cm_vld,
    output logic [SLW-1:0]       cm_slot,
    output logic [LW-1:0]        cm_len
);
    logic           active_q, has_q;
    logic [SLW-1:0] tgt_q;
    logic [LW-1:0]  cnt_q;

    logic           pick_found;
    logic [SLW-1:0] pick_slot;
    logic           eff_act, eff_has, take;
    logic [SLW-1:0] eff_tgt;
    logic [LW-1:0]  eff_cnt, cnt_after;
    logic [7:0]     free_wide;

    // Lowest free enabled buffer at this instant.
    always_comb begin
        free_wide = '0;
        free_wide[NUM_SLOTS-1:0] = free_en;
        pick_found = |free_en;
        pick_slot  = SLW'(lowest_set(free_wide, NUM_SLOTS));
    end

    // Effective frame context: a start overrides any stale context.
    always_comb begin
        eff_act   = fr_start | active_q;
        eff_has   = fr_start ? pick_found : has_q;
        eff_tgt   = fr_start ? pick_slot : tgt_q;
        eff_cnt   = fr_start ? '0 : cnt_q;
        take      = eff_act & fr_byte_vld & (eff_cnt < LW'(SLOT_BYTES));
        cnt_after = eff_cnt + LW'(take);
    end

    // Byte write and commit outputs.
    always_comb begin
        wr_vld  = take & eff_has;
        wr_slot = eff_tgt;
        wr_idx  = eff_cnt[IW-1:0];
        wr_data = fr_byte;
        cm_vld  = eff_act & fr_end & ~fr_abort & ~fr_poll & eff_has;
        cm_slot = eff_tgt;
        cm_len  = cnt_after;
    end

    // Frame context registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            has_q    <= 1'b0;
            tgt_q    <= '0;
            cnt_q    <= '0;
        end else begin
            if (fr_end || fr_abort) begin
                active_q <= 1'b0;
            end else if (fr_start) begin
                active_q <= 1'b1;
            end
            if (eff_act) begin
                has_q <= eff_has;
                tgt_q <= eff_tgt;
                cnt_q <= cnt_after;
            end
        end
    end
endmodule

// File: rtl/cec_rxb_slot.sv
// One receive buffer: byte storage, written during assembly, plus the
// committed frame length. A clear returns the length to 0 unless a commit
// into this buffer happens in the same cycle. Contents of a free buffer
// are undefined; only the length tells whether they are meaningful.
module cec_rxb_slot
    import cec_rxb_pkg::*;
#(
    parameter int SLOT_BYTES = 16,
    localparam int IW = $clog2(SLOT_BYTES),
    localparam int LW = $clog2(SLOT_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  cec_byte_t     wr_data,
    input  logic          commit,
    input  logic [LW-1:0] commit_len,
    input  logic          clr,
    input  logic [IW-1:0] rd_idx,
    output cec_byte_t     rd_data,
    output logic [LW-1:0] len
);
    cec_byte_t mem [SLOT_BYTES];

    // Byte storage write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Committed length register.
    always_ff @(posedge clk) begin
        if (!rst_n)      len <= '0;
        else if (commit) len <= commit_len;
        else if (clr)    len <= '0;
    end

    // Host read port.
    always_comb rd_data = mem[rd_idx];
endmodule

// File: rtl/cec_rxb_order.sv
// Occupancy, arrival stamps and latched ready bits for all buffers.
// Stamps run 1..N oldest to newest; clears compact the survivors, and a
// newly committed frame takes (survivor count + 1). Clears apply before a
// commit in the same cycle.
module cec_rxb_order #(
    parameter int NUM_SLOTS = 3,
    localparam int SLW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int SW  = $clog2(NUM_SLOTS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SLOTS-1:0]          clr,
    input  logic [NUM_SLOTS-1:0]          irq_mask,
    input  logic                          cm_vld,
    input  logic [SLW-1:0]                cm_slot,
    output logic [NUM_SLOTS-1:0]          occ,
    output logic [NUM_SLOTS-1:0]          rdy,
    output logic [NUM_SLOTS-1:0][SW-1:0]  stamp
);
    logic [NUM_SLOTS-1:0]         surv, gone, occ_n, rdy_n;
    logic [NUM_SLOTS-1:0][SW-1:0] stamp_n;
    logic [SW-1:0]                surv_cnt;

    // Next-state computation for occupancy, stamps and ready bits.
    always_comb begin
        surv     = occ & ~clr;
        gone     = occ & clr;
        surv_cnt = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            surv_cnt = surv_cnt + SW'(surv[i]);
        end
        for (int i = 0; i < NUM_SLOTS; i++) begin
            logic [SW-1:0] dec;
            dec = '0;
            for (int j = 0; j < NUM_SLOTS; j++) begin
                if (gone[j] && (stamp[j] < stamp[i])) dec = dec + 1'b1;
            end
            occ_n[i]   = surv[i];
            stamp_n[i] = surv[i] ? (stamp[i] - dec) : '0;
            rdy_n[i]   = rdy[i] & ~clr[i];
            if (cm_vld && (int'(cm_slot) == i)) begin
                occ_n[i]   = 1'b1;
                stamp_n[i] = surv_cnt + 1'b1;
                rdy_n[i]   = irq_mask[i];
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ   <= '0;
            rdy   <= '0;
            stamp <= '0;
        end else begin
            occ   <= occ_n;
            rdy   <= rdy_n;
            stamp <= stamp_n;
        end
    end
endmodule

// File: rtl/cec_rx_buf_mgr.sv
// Top level of the CEC multi-buffer receive manager. Wires the assembler,
// the per-buffer storage and the order tracker, builds the enable mask
// from the enable count, and provides the host read mux, interrupt and
// acknowledge permission. Assumes the receiver consults ack_ok before
// acknowledging a non-polling frame.
module cec_rx_buf_mgr
    import cec_rxb_pkg::*;
#(
    parameter int NUM_SLOTS  = 3,
    parameter int SLOT_BYTES = 16,
    localparam int SLW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int IW  = $clog2(SLOT_BYTES),
    localparam int LW  = $clog2(SLOT_BYTES + 1),
    localparam int SW  = $clog2(NUM_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fr_start,
    input  logic                 fr_byte_vld,
    input  logic [7:0]           fr_byte,
    input  logic                 fr_end,
    input  logic                 fr_abort,
    input  logic                 fr_poll,
    input  logic [NUM_SLOTS-1:0] slot_clr,
    input  logic [SW-1:0]        slot_en_cnt,
    input  logic [NUM_SLOTS-1:0] irq_mask,
    input  logic [SLW-1:0]       rd_slot,
    input  logic [IW-1:0]        rd_idx,
    output logic [7:0]           rd_data,
    output logic [LW-1:0]        rd_len,
    output logic [SW-1:0]        rd_stamp,
    output logic [NUM_SLOTS-1:0] rdy_st,
    output logic                 irq,
    output logic                 ack_ok
);
    logic [NUM_SLOTS-1:0]         en_mask, free_en, occ;
    logic [NUM_SLOTS-1:0][SW-1:0] stamp;
    logic                         wr_vld, cm_vld;
    logic [SLW-1:0]               wr_slot, cm_slot;
    logic [IW-1:0]                wr_idx;
    cec_byte_t                    wr_data;
    logic [LW-1:0]                cm_len;
    cec_byte_t                    slot_rd [NUM_SLOTS];
    logic [LW-1:0]                slot_len [NUM_SLOTS];

    // Enabled buffers: at least buffer 0, at most all of them.
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            en_mask[i] = (i == 0) || (i < int'(slot_en_cnt));
        end
        free_en = ~occ & en_mask;
    end

    cec_rxb_assembler #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_BYTES(SLOT_BYTES)
    ) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fr_start   (fr_start),
        .fr_byte_vld(fr_byte_vld),
        .fr_byte    (fr_byte),
        .fr_end     (fr_end),
        .fr_abort   (fr_abort),
        .fr_poll    (fr_poll),
        .free_en    (free_en),
        .wr_vld     (wr_vld),
        .wr_slot    (wr_slot),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .cm_vld     (cm_vld),
        .cm_slot    (cm_slot),
        .cm_len     (cm_len)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        cec_rxb_slot #(.SLOT_BYTES(SLOT_BYTES)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_vld && (int'(wr_slot) == g)),
            .wr_idx    (wr_idx),
            .wr_data   (wr_data),
            .commit    (cm_vld && (int'(cm_slot) == g)),
            .commit_len(cm_len),
            .clr       (slot_clr[g]),
            .rd_idx    (rd_idx),
            .rd_data   (slot_rd[g]),
            .len       (slot_len[g])
        );
    end

    cec_rxb_order #(.NUM_SLOTS(NUM_SLOTS)) u_order (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (slot_clr),
        .irq_mask(irq_mask),
        .cm_vld  (cm_vld),
        .cm_slot (cm_slot),
        .occ     (occ),
        .rdy     (rdy_st),
        .stamp   (stamp)
    );

    // Host read mux; an out-of-range buffer number reads as zero.
    always_comb begin
        rd_data  = '0;
        rd_len   = '0;
        rd_stamp = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (int'(rd_slot) == i) begin
                rd_data  = slot_rd[i];
                rd_len   = slot_len[i];
                rd_stamp = stamp[i];
            end
        end
    end

    // Host interrupt and receiver acknowledge permission.
    always_comb begin
        irq    = |(rdy_st & irq_mask);
        ack_ok = |free_en;
    end
endmodule

// File: rtl/cec_rxb_chk.sv
// Property checker for the receive buffer manager, bound to the top.
module cec_rxb_chk #(
    parameter int NUM_SLOTS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fr_end,
    input logic                 fr_poll,
    input logic [NUM_SLOTS-1:0] slot_clr,
    input logic [NUM_SLOTS-1:0] irq_mask,
    input logic [NUM_SLOTS-1:0] rdy_st,
    input logic [NUM_SLOTS-1:0] occ,
    input logic                 irq,
    input logic                 ack_ok
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
        AST_RDY_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rdy_st[g]) |-> $past(irq_mask[g])); // R4
        AST_RDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (rdy_st[g] && !slot_clr[g]) |=> rdy_st[g]); // R4
        AST_RDY_IMPLIES_OCC: assert property (@(posedge clk) disable iff (!rst_n)
            rdy_st[g] |-> occ[g]); // R4
        AST_CLR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_clr[g] && !fr_end) |=> (!occ[g] && !rdy_st[g])); // R10
    end

    AST_IRQ_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|rdy_st)); // R5
    AST_ACK_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |-> !(&occ)); // R6
    AST_POLL_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_end && fr_poll) |=> ((rdy_st & ~$past(rdy_st)) == '0)); // R7
endmodule

bind cec_rx_buf_mgr cec_rxb_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fr_end  (fr_end),
    .fr_poll (fr_poll),
    .slot_clr(slot_clr),
    .irq_mask(irq_mask),
    .rdy_st  (rdy_st),
    .occ     (occ),
    .irq     (irq),
    .ack_ok  (ack_ok)
);

// File: tb/tb_cec_rx_buf_mgr.sv
module tb_cec_rx_buf_mgr;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       fr_start, fr_byte_vld, fr_end, fr_abort, fr_poll;
    logic [7:0] fr_byte;
    logic [2:0] slot_clr, irq_mask;
    logic [1:0] slot_en_cnt, rd_slot, rd_stamp;
    logic [3:0] rd_idx;
    logic [7:0] rd_data;
    logic [4:0] rd_len;
    logic [2:0] rdy_st;
    logic       irq, ack_ok;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    cec_rx_buf_mgr dut (
        .clk(clk), .rst_n(rst_n), .fr_start(fr_start), .fr_byte_vld(fr_byte_vld),
        .fr_byte(fr_byte), .fr_end(fr_end), .fr_abort(fr_abort), .fr_poll(fr_poll),
        .slot_clr(slot_clr), .slot_en_cnt(slot_en_cnt), .irq_mask(irq_mask),
        .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_data(rd_data), .rd_len(rd_len),
        .rd_stamp(rd_stamp), .rdy_st(rdy_st), .irq(irq), .ack_ok(ack_ok)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] en, input logic [2:0] mask);
        @(negedge clk);
        rst_n = 1'b0; fr_start = 0; fr_byte_vld = 0; fr_end = 0; fr_abort = 0;
        fr_poll = 0; fr_byte = 0; slot_clr = 0; rd_slot = 0; rd_idx = 0;
        slot_en_cnt = en; irq_mask = mask;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Frame of n bytes, byte k = seed + k; ends with end or abort.
    task automatic send_frame(input int seed, input int n, input logic poll,
                              input logic abort);
        @(negedge clk);
        fr_start = 1; fr_byte_vld = 1; fr_byte = 8'(seed);
        for (int k = 1; k < n; k++) begin
            @(negedge clk);
            fr_start = 0; fr_byte = 8'(seed + k);
        end
        @(negedge clk);
        fr_start = 0; fr_byte_vld = 0;
        if (abort) fr_abort = 1; else begin fr_end = 1; fr_poll = poll; end
        @(negedge clk);
        fr_end = 0; fr_abort = 0; fr_poll = 0;
    endtask

    task automatic clear(input logic [2:0] m);
        @(negedge clk);
        slot_clr = m;
        @(negedge clk);
        slot_clr = 0;
    endtask

    task automatic peek(input int s, input int idx);
        rd_slot = 2'(s); rd_idx = 4'(idx);
        #1;
    endtask

    // Vector: {op, len, poll, clr_mask, exp_rdy, exp_ack}; op 0 frame, 1 clear.
    localparam int NV = 10;
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 5'd3,  1'b0, 3'b000, 3'b001, 1'b1},  // R1 slot0
        {1'b0, 5'd1,  1'b1, 3'b000, 3'b001, 1'b1},  // R7 poll
        {1'b0, 5'd5,  1'b0, 3'b000, 3'b011, 1'b1},  // R1 slot1
        {1'b0, 5'd16, 1'b0, 3'b000, 3'b111, 1'b0},  // R6 full
        {1'b0, 5'd4,  1'b0, 3'b000, 3'b111, 1'b0},  // R11 dropped
        {1'b1, 5'd0,  1'b0, 3'b010, 3'b101, 1'b1},  // R10 free slot1
        {1'b0, 5'd2,  1'b0, 3'b000, 3'b111, 1'b0},  // R1 reuse slot1
        {1'b1, 5'd0,  1'b0, 3'b101, 3'b010, 1'b1},  // R10
        {1'b0, 5'd7,  1'b0, 3'b000, 3'b011, 1'b1},  // R1 slot0 again
        {1'b1, 5'd0,  1'b0, 3'b011, 3'b000, 1'b1}   // R10 all free
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset(2'd3, 3'b111);
        @(negedge clk);
        check("R4 reset rdy", int'(rdy_st), 0);
        check("R6 reset ack", int'(ack_ok), 1);
        check("R5 reset irq", int'(irq), 0);
        peek(0, 0);
        check("R10 reset len", int'(rd_len), 0);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][13]) clear(VEC[v][6:4]);
            else send_frame(v * 16, int'(VEC[v][12:8]), VEC[v][7], 1'b0);
            check($sformatf("R1/R6 vec%0d rdy", v), int'(rdy_st), int'(VEC[v][3:1]));
            check($sformatf("R6 vec%0d ack", v), int'(ack_ok), int'(VEC[v][0]));
            check($sformatf("R5 vec%0d irq", v), int'(irq), int'(VEC[v][3:1] != 0));
        end

        // Stamps, storage and release compaction
        do_reset(2'd3, 3'b111);
        send_frame(8'h10, 3, 0, 0);
        send_frame(8'h20, 2, 0, 0);
        send_frame(8'h30, 4, 0, 0);
        for (int s = 0; s < 3; s++) begin
            peek(s, 0);
            check($sformatf("R3 stamp slot%0d", s), int'(rd_stamp), s + 1);
        end
        peek(2, 3);
        check("R2 data slot2 idx3", int'(rd_data), 8'h33);
        check("R2 len slot2", int'(rd_len), 4);
        clear(3'b001);
        peek(0, 0);
        check("R3 freed stamp", int'(rd_stamp), 0);
        check("R10 freed len", int'(rd_len), 0);
        peek(1, 0); check("R3 slot1 dec", int'(rd_stamp), 1);
        peek(2, 0); check("R3 slot2 dec", int'(rd_stamp), 2);
        send_frame(8'h40, 2, 0, 0);
        peek(0, 1);
        check("R3 newest stamp", int'(rd_stamp), 3);
        check("R2 data slot0 idx1", int'(rd_data), 8'h41);
        clear(3'b110);
        peek(0, 0);
        check("R3 two cleared", int'(rd_stamp), 1);
        clear(3'b010);
        check("R10 clear free no effect", int'(rdy_st), 3'b001);
        peek(0, 0);
        check("R10 clear free len", int'(rd_len), 2);

        // Overlength truncation
        do_reset(2'd3, 3'b111);
        send_frame(8'h50, 18, 0, 0);
        peek(0, 15);
        check("R2 capped len", int'(rd_len), 16);
        check("R2 last kept byte", int'(rd_data), 8'h5F);
        peek(0, 0);
        check("R2 header kept", int'(rd_data), 8'h50);

        // Abort and poll
        do_reset(2'd3, 3'b111);
        send_frame(8'h60, 3, 0, 1);
        peek(0, 0);
        check("R9 abort rdy", int'(rdy_st), 0);
        check("R9 abort len", int'(rd_len), 0);
        check("R9 abort stamp", int'(rd_stamp), 0);
        send_frame(8'h70, 2, 0, 0);
        check("R9 slot0 still free", int'(rdy_st), 3'b001);
        send_frame(8'h80, 1, 1, 0);
        peek(1, 0);
        check("R7 poll len", int'(rd_len), 0);
        check("R7 poll rdy", int'(rdy_st), 3'b001);

        // Mask gating
        do_reset(2'd3, 3'b110);
        send_frame(8'h90, 2, 0, 0);
        peek(0, 0);
        check("R4 masked rdy", int'(rdy_st), 0);
        check("R5 masked irq", int'(irq), 0);
        check("R2 masked stored len", int'(rd_len), 2);
        send_frame(8'hA0, 2, 0, 0);
        check("R4 unmasked rdy", int'(rdy_st), 3'b010);
        check("R5 irq", int'(irq), 1);
        @(negedge clk); irq_mask = 3'b100; #1;
        check("R5 mask drop irq", int'(irq), 0);

        // Single buffer mode
        do_reset(2'd0, 3'b111);
        send_frame(8'hB0, 3, 0, 0);
        check("R8 single rdy", int'(rdy_st), 3'b001);
        check("R8 single ack", int'(ack_ok), 0);
        send_frame(8'hC0, 3, 0, 0);
        peek(1, 0);
        check("R11 drop len", int'(rd_len), 0);
        check("R11 drop rdy", int'(rdy_st), 3'b001);
        peek(0, 0);
        check("R11 slot0 kept", int'(rd_data), 8'hB0);
        clear(3'b001);
        check("R6 ack restored", int'(ack_ok), 1);
        @(negedge clk); slot_en_cnt = 2'd2;
        send_frame(8'hD0, 1, 0, 0);
        send_frame(8'hE0, 1, 0, 0);
        check("R8 two enabled", int'(rdy_st), 3'b011);
        check("R8 two full ack", int'(ack_ok), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule